// File: doc/BRIEF.md
# Watchdog Timer with Locked Oscillator Mode

This block is a 15-bit down-counting watchdog for a small microcontroller. In its normal mode it counts enable pulses from the CPU-side clock after a prescaler of 16 or 128. In its protective mode it counts pulses from a free-running on-chip oscillator instead. In that mode it also keeps counting while the CPU is in wait or hold, and it refuses software requests to enter stop mode. When the count runs out, the block raises either a one-cycle interrupt request or a sticky reset request.

Software uses four byte-wide registers on a simple bus. Writing any value to the refresh register reloads the counter to all ones and starts it. The control register returns the prescaler choice and the five top bits of the live count. The mode register holds the reset-on-expiry and oscillator-source bits, which software can only set. The system register carries the write-enable bit that guards the mode register, together with the stop-request bit. Both clock sources arrive as single-cycle enable pulses in the block's clock domain.

Top module: `wdt_guard`

## Requirements
- R1: A write of any data to the refresh register (address 1) loads the counter with 7FFFh and starts counting. Before the first such write after reset the counter does not move.
- R2: Reading address 0 returns the prescaler select in bit 7, zeros in bits 6 and 5, and counter bits 14 to 10 in bits 4 to 0. Address 1 always reads 0. Address 2 returns the oscillator-source bit in bit 1 and the reset-on-expiry bit in bit 0. Address 3 returns the write-enable bit in bit 0.
- R3: In normal mode the counter decrements once per 16 CPU tick pulses while control bit 7 is 0, and once per 128 pulses while it is 1.
- R4: Writes to the mode register (address 2) take effect only while the write-enable bit (address 3, bit 0) is 1.
- R5: When a count pulse arrives with the counter at 0 and reset-on-expiry is 0, the counter reloads to 7FFFh and `irq` is high for exactly one cycle, in the cycle after that edge. The expiry therefore comes 32768 count pulses after a refresh.
- R6: When the counter expires with reset-on-expiry set (mode bit 0), `rstReq` rises in the next cycle. It stays high and counting halts until `rstN` is asserted.
- R7: With the oscillator-source bit set (mode bit 1), each `oscTick` pulse decrements the counter by one. `cpuTick` and the prescaler are then ignored.
- R8: Writing 1 to system register bit 1 pulses `stopReq` for one cycle. While the oscillator-source bit is 1, `stopBlocked` is high and such writes produce no pulse.
- R9: In normal mode the counter holds while `waitHold` is high. With the oscillator-source bit set it keeps counting.
- R10: Once set, the oscillator-source and reset-on-expiry bits ignore software writes of 0, even with write enable set. Only `rstN` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWrData | input | 8 | Write data |
| rdData | output | 8 | Read data for busAddr, combinational |
| cpuTick | input | 1 | CPU-side count clock enable pulse |
| oscTick | input | 1 | On-chip oscillator enable pulse |
| waitHold | input | 1 | CPU is in wait mode or hold state |
| irq | output | 1 | One-cycle expiry interrupt request |
| rstReq | output | 1 | Sticky expiry reset request |
| stopReq | output | 1 | One-cycle stop-mode entry request |
| stopBlocked | output | 1 | Stop-mode requests are disabled |

## Verification
A register write takes effect at the clock edge on which `busWr` is sampled. `irq`, `rstReq` and `stopReq` all come from registers, so each is due in the cycle after the edge that caused it. `rdData` follows `busAddr` in the same cycle.

The bench's reference model advances at each rising edge from the inputs held since the previous falling edge. It compares all outputs 3 ns after every edge. Directed checks drive inputs on the falling edge and sample 1 ns later. Each check therefore sees exactly the number of edges it counted.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [1:0] ADDR_CTRL    = 2'd0;
  localparam logic [1:0] ADDR_REFRESH = 2'd1;
  localparam logic [1:0] ADDR_MODE    = 2'd2;
  localparam logic [1:0] ADDR_SYS     = 2'd3;

  localparam int BUS_W  = 8;
  localparam int HIGH_W = 5;

  typedef struct packed {
    logic load;
    logic runCpu;
    logic runOsc;
    logic divHi;
  } wdt_strobe_t;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdt_strobe_t      strobe,
  input  logic             cpuTick,
  input  logic             oscTick,
  output logic [CNT_W-1:0] cntVal,
  output logic             underflow
);

  localparam int PRE_W = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;
  localparam logic [PRE_W-1:0] LIM_LO = PRE_W'(DIV_LO - 1);
  localparam logic [PRE_W-1:0] LIM_HI = PRE_W'(DIV_HI - 1);
  localparam logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}};

  logic [PRE_W-1:0] preCnt;
  logic             preWrap;
  logic             cpuAdv;
  logic             decTick;
  logic             atZero;

  assign preWrap   = preCnt >= (strobe.divHi ? LIM_HI : LIM_LO);
  assign cpuAdv    = strobe.runCpu && cpuTick;
  assign decTick   = (cpuAdv && preWrap) || (strobe.runOsc && oscTick);
  assign atZero    = (cntVal == '0);
  assign underflow = !strobe.load && decTick && atZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (strobe.load) begin
      preCnt <= '0;
    end else if (cpuAdv) begin
      preCnt <= preWrap ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= RELOAD;
    end else if (strobe.load) begin
      cntVal <= RELOAD;
    end else if (decTick) begin
      cntVal <= atZero ? RELOAD : cntVal - 1'b1;
    end
  end

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [BUS_W-1:0] busWrData,
  input  logic             waitHold,
  input  logic             underflow,
  input  logic [CNT_W-1:0] cntVal,
  output wdt_strobe_t      strobe,
  output logic [BUS_W-1:0] rdData,
  output logic             irq,
  output logic             rstReq,
  output logic             stopReq,
  output logic             stopBlocked
);

  logic divHi;
  logic rstMode;
  logic oscSrc;
  logic writeEn;
  logic started;

  logic wrCtrl;
  logic wrRefresh;
  logic wrMode;
  logic wrSys;

  assign wrCtrl    = busWr && (busAddr == ADDR_CTRL);
  assign wrRefresh = busWr && (busAddr == ADDR_REFRESH);
  assign wrMode    = busWr && (busAddr == ADDR_MODE);
  assign wrSys     = busWr && (busAddr == ADDR_SYS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divHi   <= 1'b0;
      rstMode <= 1'b0;
      oscSrc  <= 1'b0;
      writeEn <= 1'b0;
      started <= 1'b0;
      irq     <= 1'b0;
      rstReq  <= 1'b0;
      stopReq <= 1'b0;
    end else begin
      irq     <= underflow && !rstMode;
      stopReq <= wrSys && busWrData[1] && !oscSrc;
      if (underflow && rstMode) rstReq <= 1'b1;
      if (wrCtrl) divHi <= busWrData[7];
      if (wrRefresh) started <= 1'b1;
      if (wrMode && writeEn) begin
        rstMode <= rstMode | busWrData[0];
        oscSrc  <= oscSrc | busWrData[1];
      end
      if (wrSys) writeEn <= busWrData[0];
    end
  end

  always_comb begin
    strobe.load   = wrRefresh;
    strobe.runCpu = started && !oscSrc && !waitHold && !rstReq;
    strobe.runOsc = started && oscSrc && !rstReq;
    strobe.divHi  = divHi;
  end

  assign stopBlocked = oscSrc;

  always_comb begin
    rdData = '0;
    unique case (busAddr)
      ADDR_CTRL:    rdData = {divHi, 2'b00, cntVal[CNT_W-1 -: HIGH_W]};
      ADDR_REFRESH: rdData = '0;
      ADDR_MODE:    rdData = {6'b0, oscSrc, rstMode};
      ADDR_SYS:     rdData = {7'b0, writeEn};
      default:      rdData = '0;
    endcase
  end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWrData,
  output logic [7:0] rdData,
  input  logic       cpuTick,
  input  logic       oscTick,
  input  logic       waitHold,
  output logic       irq,
  output logic       rstReq,
  output logic       stopReq,
  output logic       stopBlocked
);

  wdt_strobe_t      strobe;
  logic [CNT_W-1:0] cntVal;
  logic             underflow;

  wdt_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .waitHold(waitHold), .underflow(underflow),
    .cntVal(cntVal), .strobe(strobe), .rdData(rdData), .irq(irq),
    .rstReq(rstReq), .stopReq(stopReq), .stopBlocked(stopBlocked)
  );

  wdt_datapath #(.CNT_W(CNT_W), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuTick(cpuTick),
    .oscTick(oscTick), .cntVal(cntVal), .underflow(underflow)
  );

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWr,
  input logic [1:0]       busAddr,
  input logic [7:0]       rdData,
  input logic             waitHold,
  input logic             irq,
  input logic             rstReq,
  input logic             stopReq,
  input logic             stopBlocked,
  input logic [CNT_W-1:0] cntVal
);

  assert_refresh_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd1) |=> (cntVal == {CNT_W{1'b1}}));

  assert_ctrl_reserved_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd0) |-> (rdData[6:5] == 2'b00));

  assert_refresh_reads_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd1) |-> (rdData == 8'h00));

  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  assert_irq_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(irq && rstReq));

  assert_rstreq_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> rstReq);

  assert_stop_blocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    stopBlocked |-> !stopReq);

  assert_wait_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
    (waitHold && !stopBlocked && !(busWr && busAddr == 2'd1)) |=> $stable(cntVal));

  assert_osc_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    stopBlocked |=> stopBlocked);

endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .rdData(rdData),
  .waitHold(waitHold), .irq(irq), .rstReq(rstReq), .stopReq(stopReq),
  .stopBlocked(stopBlocked), .cntVal(cntVal)
);

// File: tb/wdt_guard_tb_top.sv
`timescale 1ns/1ps
module wdt_guard_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] rdData;
  logic       cpuTick = 1'b0;
  logic       oscTick = 1'b0;
  logic       waitHold = 1'b0;
  logic       irq, rstReq, stopReq, stopBlocked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdt_guard dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .rdData(rdData), .cpuTick(cpuTick),
    .oscTick(oscTick), .waitHold(waitHold), .irq(irq), .rstReq(rstReq),
    .stopReq(stopReq), .stopBlocked(stopBlocked)
  );

  // Behavioural reference model
  int  mCnt = 32767, mPre = 0;
  bit  mStarted, mSel, mRst, mOsc, mProt, mIrq, mRstReq, mStop;

  function automatic logic [7:0] modelRd(logic [1:0] a);
    case (a)
      2'd0:    return {mSel, 2'b00, 5'((mCnt >> 10) & 31)};
      2'd2:    return {6'b0, mOsc, mRst};
      2'd3:    return {7'b0, mProt};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 32767; mPre = 0; mStarted = 0; mSel = 0; mRst = 0; mOsc = 0;
      mProt = 0; mIrq = 0; mRstReq = 0; mStop = 0;
    end else begin
      bit wS, wC, wM, wY, tick, runC, runO;
      int lim;
      wS = busWr && busAddr == 2'd1;
      wC = busWr && busAddr == 2'd0;
      wM = busWr && busAddr == 2'd2;
      wY = busWr && busAddr == 2'd3;
      runC = mStarted && !mOsc && !waitHold && !mRstReq;
      runO = mStarted && mOsc && !mRstReq;
      lim = mSel ? 127 : 15;
      tick = 0;
      mIrq = 0;
      if (wS) begin
        mCnt = 32767; mPre = 0; mStarted = 1;
      end else begin
        if (runC && cpuTick) begin
          if (mPre >= lim) begin tick = 1; mPre = 0; end
          else mPre = mPre + 1;
        end
        if (runO && oscTick) tick = 1;
        if (tick) begin
          if (mCnt == 0) begin
            mCnt = 32767;
            if (mRst) mRstReq = 1; else mIrq = 1;
          end else mCnt = mCnt - 1;
        end
      end
      mStop = wY && busWrData[1] && !mOsc;
      if (wC) mSel = busWrData[7];
      if (wM && mProt) begin
        mRst = mRst | busWrData[0];
        mOsc = mOsc | busWrData[1];
      end
      if (wY) mProt = busWrData[0];
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #3;
    if (rstN && !done) begin
      chk(irq == mIrq, "R5 irq model", irq, mIrq);
      chk(rstReq == mRstReq, "R6 rstReq model", rstReq, mRstReq);
      chk(stopReq == mStop, "R8 stopReq model", stopReq, mStop);
      chk(stopBlocked == mOsc, "R8 stopBlocked model", stopBlocked, mOsc);
      chk(rdData == modelRd(busAddr), "R2 rdData model", rdData, modelRd(busAddr));
    end
  end

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end");
    finishRun();
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0; busAddr = 2'd0;
  endtask

  task automatic rdChk(logic [1:0] a, logic [7:0] exp, string req);
    busAddr = a;
    #1;
    chk(rdData == exp, req, rdData, exp);
    busAddr = 2'd0;
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // Reset state
    chk(irq == 0 && rstReq == 0 && stopReq == 0 && stopBlocked == 0,
        "R6 reset outputs", {irq, rstReq, stopReq, stopBlocked}, 0);
    rdChk(2'd0, 8'h1F, "R2 reset ctrl");
    rdChk(2'd1, 8'h00, "R2 refresh reads zero");
    rdChk(2'd2, 8'h00, "R2 reset mode");
    rdChk(2'd3, 8'h00, "R2 reset sys");

    // R1: no counting before first refresh
    cpuTick = 1'b1;
    idle(16400);
    rdChk(2'd0, 8'h1F, "R1 idle before refresh");

    // R1/R3: refresh then divide by 16
    wr(2'd1, 8'hA5);
    idle(16400);
    rdChk(2'd0, 8'h1E, "R3 divide by 16");

    // R9: normal mode frozen during wait/hold
    waitHold = 1'b1;
    wr(2'd1, 8'h00);
    idle(16400);
    rdChk(2'd0, 8'h1F, "R9 normal wait freeze");
    waitHold = 1'b0;

    // R2/R3: prescaler by 128, reserved bits read zero
    wr(2'd0, 8'hE0);
    wr(2'd1, 8'h00);
    idle(16400);
    rdChk(2'd0, 8'h9F, "R3 divide by 128");

    // R4: mode writes blocked without write enable
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h03);
    rdChk(2'd2, 8'h00, "R4 protected mode write");
    chk(stopBlocked == 0, "R4 stopBlocked unchanged", stopBlocked, 0);

    // R8: stop request allowed in normal mode
    wr(2'd3, 8'h02);
    chk(stopReq == 1, "R8 stop pulse", stopReq, 1);
    idle(1);
    chk(stopReq == 0, "R8 stop pulse ends", stopReq, 0);

    // R4/R10: enable osc source, then attempt clear
    wr(2'd3, 8'h01);
    wr(2'd2, 8'h02);
    rdChk(2'd2, 8'h02, "R4 enabled mode write");
    chk(stopBlocked == 1, "R8 stopBlocked set", stopBlocked, 1);
    wr(2'd2, 8'h00);
    rdChk(2'd2, 8'h02, "R10 osc bit sticky");
    wr(2'd3, 8'h03);
    chk(stopReq == 0, "R8 stop blocked", stopReq, 0);

    // R5/R7/R9: oscillator counting through wait, interrupt expiry
    cpuTick = 1'b0;
    waitHold = 1'b1;
    oscTick = 1'b1;
    wr(2'd1, 8'h00);
    idle(32767);
    chk(irq == 0, "R5 no irq before expiry", irq, 0);
    rdChk(2'd0, 8'h80, "R7 counter at zero");
    idle(1);
    chk(irq == 1, "R5 irq on expiry", irq, 1);
    rdChk(2'd0, 8'h9F, "R5 reload after expiry");
    idle(1);
    chk(irq == 0, "R5 irq one cycle", irq, 0);

    // R6: reset-on-expiry mode
    wr(2'd2, 8'h01);
    rdChk(2'd2, 8'h03, "R10 both bits set");
    wr(2'd1, 8'h00);
    idle(32767);
    chk(rstReq == 0, "R6 no reset before expiry", rstReq, 0);
    idle(1);
    chk(rstReq == 1 && irq == 0, "R6 reset request", {rstReq, irq}, 2);
    idle(200);
    chk(rstReq == 1, "R6 reset request held", rstReq, 1);
    rdChk(2'd0, 8'h9F, "R6 counting halted");

    // R10: only system reset clears sticky bits
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(1);
    chk(rstReq == 0, "R6 cleared by reset", rstReq, 0);
    rdChk(2'd2, 8'h00, "R10 cleared by reset");
    idle(2);
    finishRun();
  end

endmodule